// File: doc/BRIEF.md
# Adjacent-Ones Run Detector

This block examines one parallel data word and raises a single flag whenever the word holds a run of at least `RUN_LEN` neighbouring bits that are all 1. It has no clock and no state. The output follows the input through a fixed two-level path: an AND over each window of neighbouring bits, then an OR across all windows.

The word width `WIDTH` defaults to 8 and the run length `RUN_LEN` defaults to 3. With these defaults there are six windows. Windows stop at the ends of the word, so the most significant and least significant bits are never treated as neighbours. A typical use is a guard that flags data words holding a burst of set bits before they move further down a datapath.

Top module: `run_detect`

## Requirements
- R1: `hit_o` is 1 exactly when some `RUN_LEN` consecutive bit positions of `data_i` are all 1, and 0 otherwise, for every input value.
- R2: The input 8'b00011101 gives `hit_o` = 1. It holds a run of three at bits 4..2.
- R3: Alternating patterns never form a run. The inputs 8'b10101011 and 8'b01010101 give `hit_o` = 0.
- R4: A run longer than `RUN_LEN` also counts. The inputs 8'b11110000 and 8'b01111110 give `hit_o` = 1.
- R5: There is no wrap-around between bit `WIDTH-1` and bit 0. The inputs 8'b11000001 and 8'b10000011 give `hit_o` = 0.
- R6: An all-zero input gives `hit_o` = 0 and an all-ones input gives `hit_o` = 1.
- R7: A run placed at either end of the word is detected. The inputs 8'b11100000 and 8'b00000111 give `hit_o` = 1.
- R8: Several runs that are each shorter than `RUN_LEN` do not count. The inputs 8'b11011011 and 8'b01101101 give `hit_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to examine; bit WIDTH-1 is the most significant |
| hit_o | output | 1 | 1 when a run of at least RUN_LEN ones is present |

## Verification
The bench targets the boundaries between windows:
- Runs at the top and the bottom of the word: an off-by-one window range would drop the first or last window, and the flag would stay 0.
- Patterns split across the word ends: a design that wrapped would wrongly flag 11000001.
- Groups of two ones separated by a zero, and alternating bits: a window narrower than `RUN_LEN` would flag these.

An exhaustive sweep of all 256 words, checked against a run-length count done in the bench, catches any stray wrong value.

// File: rtl/run_detect_pkg.sv
package run_detect_pkg;
  // Number of sliding windows for a given word width and run length
  function automatic int unsigned win_count(input int unsigned width, input int unsigned run_len);
    return width - run_len + 1;
  endfunction
endpackage

// File: rtl/run_window.sv
module run_window #(
  parameter int unsigned RUN_LEN = 3
) (
  input  logic [RUN_LEN-1:0] slice_i,
  output logic               all_ones_o
);
  assign all_ones_o = &slice_i;
endmodule

// File: rtl/run_or_reduce.sv
module run_or_reduce #(
  parameter int unsigned N_IN = 6
) (
  input  logic [N_IN-1:0] hits_i,
  output logic            any_o
);
  assign any_o = |hits_i;
endmodule

// File: rtl/run_detect.sv
module run_detect
  import run_detect_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned RUN_LEN = 3
) (
  input  logic [WIDTH-1:0] data_i,
  output logic             hit_o
);
  localparam int unsigned NWIN = win_count(WIDTH, RUN_LEN);

  logic [NWIN-1:0] win_hit;

  generate
    if (RUN_LEN == 0 || RUN_LEN > WIDTH) begin : g_bad_cfg
      $error("run_detect: RUN_LEN must be in 1..WIDTH");
    end
    // window k spans bits k+RUN_LEN-1 down to k; no wrap past the word ends
    for (genvar k = 0; k < NWIN; k++) begin : g_win
      run_window #(.RUN_LEN(RUN_LEN)) u_win (
        .slice_i   (data_i[k+RUN_LEN-1:k]),
        .all_ones_o(win_hit[k])
      );
    end
  endgenerate

  run_or_reduce #(.N_IN(NWIN)) u_or (
    .hits_i(win_hit),
    .any_o (hit_o)
  );
endmodule

// File: rtl/run_detect_chk.sv
module run_detect_chk #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned RUN_LEN = 3
) (
  input logic [WIDTH-1:0] data_i,
  input logic             hit_o
);
  int unsigned longest;
  int unsigned cur;

  // longest run of ones, found by a serial scan rather than by windows
  always_comb begin
    longest = 0;
    cur     = 0;
    for (int i = 0; i < WIDTH; i++) begin
      if (data_i[i]) cur = cur + 1;
      else           cur = 0;
      if (cur > longest) longest = cur;
    end
  end

  always_comb begin
    if (!$isunknown(data_i)) begin
      a_r1_run_match: assert (hit_o == (longest >= RUN_LEN))
        else $error("R1: flag disagrees with longest run");
      a_r6_zero_clear: assert (data_i != '0 || !hit_o)
        else $error("R6: zero word flagged");
      a_r6_ones_set: assert (data_i != '1 || hit_o)
        else $error("R6: all-ones word not flagged");
      a_r8_enough_ones: assert (!hit_o || $countones(data_i) >= RUN_LEN)
        else $error("R8: flag with too few ones");
    end
  end
endmodule

bind run_detect run_detect_chk #(.WIDTH(WIDTH), .RUN_LEN(RUN_LEN)) u_chk (
  .data_i(data_i),
  .hit_o (hit_o)
);

// File: tb/sim_run_detect.sv
`timescale 1ns/1ps
module sim_run_detect;
  localparam int unsigned WIDTH   = 8;
  localparam int unsigned RUN_LEN = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [WIDTH-1:0] data;
  logic hit;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  run_detect #(.WIDTH(WIDTH), .RUN_LEN(RUN_LEN)) u0 (.data_i(data), .hit_o(hit));

  function automatic logic model(input logic [WIDTH-1:0] d);
    int run = 0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      run = d[i] ? run + 1 : 0;
      if (run >= RUN_LEN) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic apply_check(input logic [WIDTH-1:0] d, input logic exp, input string req);
    @(posedge clk);
    data = d;
    @(negedge clk);
    checks++;
    if (hit !== exp) begin
      fails++;
      $display("FAIL %s data=%b hit=%b expected=%b", req, d, hit, exp);
    end
  endtask

  task automatic t_r2_example();   apply_check(8'b00011101, 1'b1, "R2"); endtask
  task automatic t_r3_alternate();
    apply_check(8'b10101011, 1'b0, "R3");
    apply_check(8'b01010101, 1'b0, "R3");
  endtask
  task automatic t_r4_long_run();
    apply_check(8'b11110000, 1'b1, "R4");
    apply_check(8'b01111110, 1'b1, "R4");
  endtask
  task automatic t_r5_no_wrap();
    apply_check(8'b11000001, 1'b0, "R5");
    apply_check(8'b10000011, 1'b0, "R5");
  endtask
  task automatic t_r6_extremes();
    apply_check(8'h00, 1'b0, "R6");
    apply_check(8'hFF, 1'b1, "R6");
  endtask
  task automatic t_r7_edges();
    apply_check(8'b11100000, 1'b1, "R7");
    apply_check(8'b00000111, 1'b1, "R7");
  endtask
  task automatic t_r8_short_runs();
    apply_check(8'b11011011, 1'b0, "R8");
    apply_check(8'b01101101, 1'b0, "R8");
  endtask
  task automatic t_r1_sweep();
    for (int v = 0; v < (1 << WIDTH); v++)
      apply_check(v[WIDTH-1:0], model(v[WIDTH-1:0]), "R1");
  endtask

  initial begin
    #50000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    data = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;  // initial state with zero input, R6
    if (hit !== 1'b0) begin
      fails++;
      $display("FAIL R6 start hit=%b expected=0", hit);
    end
    t_r2_example();
    t_r3_alternate();
    t_r4_long_run();
    t_r5_no_wrap();
    t_r6_extremes();
    t_r7_edges();
    t_r8_short_runs();
    t_r1_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule